// File: doc/BRIEF.md
# Bus-Tracking Address Pin Decoder

This block works out a 7-bit slave address, and the power-up level of two groups of outputs, from two address-select pins. Each pin may be tied to ground, to supply, to the serial clock line or to the serial data line. A level on its own cannot tell a bus line from supply, so the block watches each pin during bus traffic. A pin that follows SCL or SDA through a whole transmission, and goes low at least once, is taken to be tied to that line. Otherwise its static level decides between supply and ground.

The pin levels come in already synchronised, together with SCL, SDA and a strobe that is high while a transmission is in progress. The classification is rebuilt on every transmission, whichever device that transmission addresses. The new result takes effect only once the transmission ends, so the address never changes inside a transaction. Until the first transmission has finished, each pin's idle level decides its class and the valid flag stays low. A pin tied to a bus line idles high, so it reads as supply.

Top module: `adpd_addr_decoder`

## Requirements
- R1: Address bits 6..4 are always 1, 0, 1.
- R2: The upper pin (`adr_pin[1]`) drives address bits 3..2 with these codes: SCL 00, SDA 01, ground 10, supply 11.
- R3: The lower pin (`adr_pin[0]`) drives address bits 1..0 with these codes: ground 00, supply 01, SCL 10, SDA 11.
- R4: During and after reset, and until the first transmission ends, a pin's class comes from its level while the bus is idle: high gives supply and low gives ground. `addr_valid` stays 0 in this period. While reset is held, both pins read as supply.
- R5: A pin is classed as following a line only if it equalled that line in every sample of the transmission and was low in at least one sample.
- R6: A pin that is not classed as following a line is classed as supply if it was never low during the transmission, and as ground otherwise.
- R7: A pin that meets the following rule for both SCL and SDA is classed as SCL.
- R8: While `xfer_active` is high, the outputs do not change. A new classification appears on the outputs one clock after the first cycle in which `xfer_active` is sampled low.
- R9: Every transmission fully replaces the previous classification. Nothing carries over from earlier transmissions.
- R10: `grp_dflt_hi[i]` is 0 when pin i is classed as ground, and 1 for supply, SCL or SDA. Index 1 selects the default for the upper output group and index 0 for the lower group.
- R11: `addr_valid` rises after the first completed transmission and stays high until the next synchronous reset. That reset clears it and brings back the idle-level mode of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adr_pin | input | 2 | Synchronised levels of the two address-select pins (index 1 is the upper pin) |
| scl | input | 1 | Synchronised serial clock line |
| sda | input | 1 | Synchronised serial data line |
| xfer_active | input | 1 | High from the start condition to the stop condition of a transmission |
| slave_addr | output | 7 | Decoded 7-bit slave address |
| addr_valid | output | 1 | High once a transmission has been classified |
| grp_dflt_hi | output | 2 | Per-pin power-up default select for its output group, 1 = high |

## Verification
The bench builds the block with its default parameters: a 7-bit address, two pins and the 101 prefix. With these, both code tables are in use, and the lower pin's table is a reordering of the upper pin's, so a swapped table shows up at once. Random transmissions cover every tie type, plus pins that toggle at random. Directed cases add bus lines held high throughout, SCL and SDA moving in lockstep, one-sample transmissions, and a reset in the middle of a run.

// File: rtl/adpd_pkg.sv
// Package: shared tie classes and per-pin code tables for the address pin decoder.
// Assumes odd pin indices use the upper table and even indices the lower one.
package adpd_pkg;

    // What an address-select pin is connected to
    typedef enum logic [1:0] {
        TIE_SCL = 2'd0,
        TIE_SDA = 2'd1,
        TIE_GND = 2'd2,
        TIE_SUP = 2'd3
    } tie_e;

    // Two-bit address code for a pin class; the table depends on the pin position
    function automatic logic [1:0] tie_code(input int pin_idx, input tie_e t);
        logic [1:0] c;
        if ((pin_idx % 2) == 1) begin
            case (t)
                TIE_SCL: c = 2'b00;
                TIE_SDA: c = 2'b01;
                TIE_GND: c = 2'b10;
                default: c = 2'b11;
            endcase
        end else begin
            case (t)
                TIE_GND: c = 2'b00;
                TIE_SUP: c = 2'b01;
                TIE_SCL: c = 2'b10;
                default: c = 2'b11;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/adpd_xfer_tracker.sv
// Transmission tracker: turns the transmission-active level into start,
// continue and commit strobes.
// Assumes xfer_active is already synchronous to clk.
module adpd_xfer_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_active,
    output logic first_smp,
    output logic next_smp,
    output logic commit
);

    logic active_q;

    // Remember last cycle's transmission state
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= xfer_active;
    end

    assign first_smp = xfer_active & ~active_q;
    assign next_smp  = xfer_active &  active_q;
    assign commit    = ~xfer_active & active_q;

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({first_smp, next_smp, commit}) <= 1);

endmodule

// File: rtl/adpd_pin_classifier.sv
// Pin classifier: watches one address pin against SCL and SDA for the length
// of a transmission, and commits a class when the transmission ends.
// Assumes all inputs are synchronised and the strobes come from adpd_xfer_tracker.
module adpd_pin_classifier
    import adpd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic scl,
    input  logic sda,
    input  logic xfer_active,
    input  logic first_smp,
    input  logic next_smp,
    input  logic commit,
    output tie_e tie,
    output logic done
);

    logic follow_scl;
    logic follow_sda;
    logic saw_low;
    logic idle_lvl;
    tie_e held;
    tie_e verdict;

    // Collect the match and low evidence over the samples of a transmission
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            follow_scl <= 1'b0;
            follow_sda <= 1'b0;
            saw_low    <= 1'b0;
        end else if (first_smp) begin
            follow_scl <= (pin == scl);
            follow_sda <= (pin == sda);
            saw_low    <= ~pin;
        end else if (next_smp) begin
            follow_scl <= follow_scl & (pin == scl);
            follow_sda <= follow_sda & (pin == sda);
            saw_low    <= saw_low | ~pin;
        end
    end

    // Decide the class from the collected evidence; SCL takes priority
    always_comb begin
        if (!saw_low)        verdict = TIE_SUP;
        else if (follow_scl) verdict = TIE_SCL;
        else if (follow_sda) verdict = TIE_SDA;
        else                 verdict = TIE_GND;
    end

    // Latch the class at the end of each transmission
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= TIE_SUP;
            done <= 1'b0;
        end else if (commit) begin
            held <= verdict;
            done <= 1'b1;
        end
    end

    // Track the pin's level while the bus is idle, for use before the first commit
    always_ff @(posedge clk) begin
        if (!rst_n)            idle_lvl <= 1'b1;
        else if (!xfer_active) idle_lvl <= pin;
    end

    assign tie = done ? held : (idle_lvl ? TIE_SUP : TIE_GND);

    assert_stable_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |=> $stable(tie));

    assert_bus_tie_needs_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ((tie == TIE_SCL || tie == TIE_SDA) -> $past(saw_low)));

    assert_static_before_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (tie == TIE_SUP || tie == TIE_GND));

endmodule

// File: rtl/adpd_addr_encoder.sv
// Address encoder: maps the per-pin classes onto the slave address and the
// group default selects.
// Assumes ADDR_W leaves room for 2*PIN_CNT code bits under the fixed prefix.
module adpd_addr_encoder
    import adpd_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int PIN_CNT = 2,
    parameter logic [ADDR_W-2*PIN_CNT-1:0] FIXED_UPPER = 3'b101
) (
    input  tie_e [PIN_CNT-1:0]  ties,
    output logic [ADDR_W-1:0]   addr,
    output logic [PIN_CNT-1:0]  dflt_hi
);

    localparam int CODE_W = 2 * PIN_CNT;

    logic [CODE_W-1:0] codes;

    // One code field and one default select per pin
    for (genvar i = 0; i < PIN_CNT; i++) begin : g_pin
        assign codes[2*i +: 2] = tie_code(i, ties[i]);
        assign dflt_hi[i]      = (ties[i] != TIE_GND);
    end

    assign addr = {FIXED_UPPER, codes};

endmodule

// File: rtl/adpd_addr_decoder.sv
// Top: bus-tracking address pin decoder. Classifies each address pin
// and publishes the slave address, a valid flag and the group default selects.
// Assumes synchronised inputs and a synchronous active-low reset.
module adpd_addr_decoder
    import adpd_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int PIN_CNT = 2,
    parameter logic [ADDR_W-2*PIN_CNT-1:0] FIXED_UPPER = 3'b101
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PIN_CNT-1:0] adr_pin,
    input  logic               scl,
    input  logic               sda,
    input  logic               xfer_active,
    output logic [ADDR_W-1:0]  slave_addr,
    output logic               addr_valid,
    output logic [PIN_CNT-1:0] grp_dflt_hi
);

    logic first_smp;
    logic next_smp;
    logic commit;
    tie_e [PIN_CNT-1:0] ties;
    logic [PIN_CNT-1:0] pin_done;

    adpd_xfer_tracker u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_active(xfer_active),
        .first_smp  (first_smp),
        .next_smp   (next_smp),
        .commit     (commit)
    );

    // One classifier per address pin
    for (genvar i = 0; i < PIN_CNT; i++) begin : g_cls
        adpd_pin_classifier u_cls (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (adr_pin[i]),
            .scl        (scl),
            .sda        (sda),
            .xfer_active(xfer_active),
            .first_smp  (first_smp),
            .next_smp   (next_smp),
            .commit     (commit),
            .tie        (ties[i]),
            .done       (pin_done[i])
        );
    end

    adpd_addr_encoder #(
        .ADDR_W     (ADDR_W),
        .PIN_CNT    (PIN_CNT),
        .FIXED_UPPER(FIXED_UPPER)
    ) u_enc (
        .ties   (ties),
        .addr   (slave_addr),
        .dflt_hi(grp_dflt_hi)
    );

    assign addr_valid = &pin_done;

    assert_valid_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !$fell(addr_valid));

    assert_valid_low_after_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !addr_valid);

    assert_addr_frozen_in_xfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |=> ($stable(slave_addr) && $stable(grp_dflt_hi)));

endmodule

// File: tb/sim_adpd_addr_decoder.sv
// Self-checking bench for adpd_addr_decoder: directed corner cases plus seeded
// random transmissions, checked against a model built from the requirements.
module sim_adpd_addr_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] adr_pin = 2'b11;
    logic       scl = 1'b1;
    logic       sda = 1'b1;
    logic       xfer_active = 1'b0;
    logic [6:0] slave_addr;
    logic       addr_valid;
    logic [1:0] grp_dflt_hi;

    int checks = 0;
    int errors = 0;
    int kind_hi = 3;   // 0 SCL, 1 SDA, 2 GND, 3 SUP, 4 random wiggle
    int kind_lo = 3;
    logic [6:0] cur_addr;
    logic [1:0] cur_dflt;
    logic       cur_valid;

    always #10 clk = ~clk;

    adpd_addr_decoder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .adr_pin    (adr_pin),
        .scl        (scl),
        .sda        (sda),
        .xfer_active(xfer_active),
        .slave_addr (slave_addr),
        .addr_valid (addr_valid),
        .grp_dflt_hi(grp_dflt_hi)
    );

    function automatic logic [1:0] code_hi(input int t);
        case (t)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [1:0] code_lo(input int t);
        case (t)
            0: return 2'b10;
            1: return 2'b11;
            2: return 2'b00;
            default: return 2'b01;
        endcase
    endfunction

    function automatic void set_expect(input int th, input int tl, input logic v);
        cur_addr  = {3'b101, code_hi(th), code_lo(tl)};
        cur_dflt  = {th != 2, tl != 2};
        cur_valid = v;
    endfunction

    function automatic logic pin_val(input int kind, input logic s, input logic d);
        case (kind)
            0: return s;
            1: return d;
            2: return 1'b0;
            3: return 1'b1;
            default: return 1'($urandom);
        endcase
    endfunction

    function automatic int verdict(input bit ms, input bit md, input bit lo);
        if (!lo) return 3;
        if (ms)  return 0;
        if (md)  return 1;
        return 2;
    endfunction

    task automatic chk(input string req);
        checks++;
        if (slave_addr !== cur_addr || grp_dflt_hi !== cur_dflt || addr_valid !== cur_valid) begin
            errors++;
            $display("FAIL %s: addr=%b dflt=%b valid=%b expected addr=%b dflt=%b valid=%b",
                     req, slave_addr, grp_dflt_hi, addr_valid, cur_addr, cur_dflt, cur_valid);
        end
    endtask

    task automatic drive_idle();
        scl = 1'b1;
        sda = 1'b1;
        xfer_active = 1'b0;
        adr_pin = {(kind_hi != 2), (kind_lo != 2)};
    endtask

    // Reset with the given ties, check the reset state, then the idle-level classes (R4, R11)
    task automatic do_reset(input int kh, input int kl);
        kind_hi = kh;
        kind_lo = kl;
        @(negedge clk);
        drive_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        set_expect(3, 3, 1'b0);
        chk("R4 R11 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        set_expect((kh == 2) ? 2 : 3, (kl == 2) ? 2 : 3, 1'b0);
        chk("R4 R1 idle-level classes");
    endtask

    // One transmission of n samples; pat 0 random lines, 1 lines held high, 2 SDA equals SCL
    task automatic xfer(input int n, input int pat);
        bit ms [2];
        bit md [2];
        bit lo [2];
        logic s;
        logic d;
        logic [1:0] p;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R8 stable during transmission");
            case (pat)
                1:       begin s = 1'b1; d = 1'b1; end
                2:       begin s = 1'($urandom); d = s; end
                default: begin s = 1'($urandom); d = 1'($urandom); end
            endcase
            p = {pin_val(kind_hi, s, d), pin_val(kind_lo, s, d)};
            scl = s;
            sda = d;
            adr_pin = p;
            xfer_active = 1'b1;
            for (int i = 0; i < 2; i++) begin
                if (k == 0) begin
                    ms[i] = (p[i] == s);
                    md[i] = (p[i] == d);
                    lo[i] = !p[i];
                end else begin
                    ms[i] = ms[i] && (p[i] == s);
                    md[i] = md[i] && (p[i] == d);
                    lo[i] = lo[i] || !p[i];
                end
            end
        end
        @(negedge clk);
        chk("R8 stable through last sample");
        drive_idle();
        @(negedge clk);
        set_expect(verdict(ms[1], md[1], lo[1]), verdict(ms[0], md[0], lo[0]), 1'b1);
        chk("R1 R2 R3 R5 R6 R7 R9 R10 R11 committed class");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        set_expect(3, 3, 1'b0);

        // R4: bus-tied upper pin idles high so reads supply; lower ground
        do_reset(0, 2);
        // R5: real traffic, upper follows SCL, lower SDA
        kind_hi = 0; kind_lo = 1;
        xfer(12, 0);
        // R5 R6: lines held high -> bus-tied pins never low -> supply
        kind_hi = 0; kind_lo = 0;
        xfer(6, 1);
        // R7: SCL and SDA identical -> SDA-tied pins read SCL
        kind_hi = 1; kind_lo = 1;
        xfer(10, 2);
        // R6 R10: ground and supply through a transmission
        kind_hi = 2; kind_lo = 3;
        xfer(8, 0);
        // R9: one-sample transmission replaces everything
        kind_hi = 3; kind_lo = 2;
        xfer(1, 0);
        // R11: reset mid-run brings back idle-level mode
        do_reset(2, 1);
        kind_hi = 1; kind_lo = 0;
        xfer(9, 0);

        for (int t = 0; t < 300; t++) begin
            kind_hi = int'($urandom % 5);
            kind_lo = int'($urandom % 5);
            @(negedge clk);
            drive_idle();
            xfer(1 + int'($urandom % 16), int'($urandom % 3));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #3ms;
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule